// File: doc/BRIEF.md
# Receive Sample Strobe Generator

This block produces the sample strobe for a contactless receive path. It runs on the carrier clock recovered from the field and divides it by a programmable ratio. For 106 kbit/s reception the ratio is 32, which places four strobes in each bit period. The demodulated input is a single bit from a comparator that weighs the analog envelope against a 7-bit threshold. The block passes that threshold value through to the comparator.

While a frame is active, the block waits for the first falling edge of the synchronized comparator bit. That edge sets the divider's phase. The first strobe follows one full divider period plus a programmable phase offset after the edge. Further strobes come once per divider period. Later edges in the same frame are ignored. The block rearms only when the frame-active signal drops.

On every strobe the block latches the synchronized comparator bit, so a bit decoder downstream reads one clean sample per strobe.

Top module: `rx_strobe_gen`

## Requirements
- R1: While reset is asserted, `strobe_o`, `data_o` and `thr_level_o` are all 0.
- R2: `cmp_bit_i` passes through two synchronizer flops before edge detection. A falling edge driven in cycle f (1 in cycle f-1, 0 in cycle f) is seen in cycle f+2. The first strobe of the frame is high in cycle f+2+D+P, where D is the effective divider and P is `phase_ofs_i`.
- R3: The phase offset counts from the cycle in which the edge is seen. With `phase_ofs_i` = 0, the first strobe comes exactly D cycles after that cycle.
- R4: After the first strobe, `strobe_o` is high for one cycle every D cycles for as long as `frame_act_i` stays high.
- R5: Falling edges after the first one in a frame have no effect on strobe timing.
- R6: A cycle with `frame_act_i` low rearms the edge search, and `strobe_o` is 0 in the cycle that follows it.
- R7: A `div_ratio_i` value of 0 or 1 behaves as 2, so `strobe_o` is never high in two consecutive cycles.
- R8: In a cycle with `strobe_o` high, `data_o` equals the value `cmp_bit_i` had three cycles earlier. `data_o` changes in no other cycle.
- R9: `thr_level_o` equals the `thr_level_i` value of the previous cycle.
- R10: A frame that contains no falling edge of the synchronized input produces no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Recovered carrier clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmp_bit_i | input | 1 | Comparator output (demodulated envelope), asynchronous |
| frame_act_i | input | 1 | High while a frame is being received |
| div_ratio_i | input | DIV_W (8) | Carrier cycles per strobe; values below 2 act as 2 |
| phase_ofs_i | input | PHASE_W (8) | Extra delay in carrier cycles before the first strobe |
| thr_level_i | input | THR_W (7) | Comparator threshold, 0 to 127 |
| strobe_o | output | 1 | One-cycle sample strobe |
| data_o | output | 1 | Comparator bit latched on each strobe |
| thr_level_o | output | THR_W (7) | Registered threshold driven to the comparator |

## Verification
The comparator bit toggles at random throughout every frame, so a design that resynchronizes on later edges would shift its strobes away from the expected grid. The bench measures the first strobe from the driven edge. A synchronizer that is one flop short or long, or a phase offset that is off by one, shows up as a strobe one cycle early or late. The divider values 0 and 1 are exercised: a design without the clamp would emit strobes in back-to-back cycles or none at all. Some frames are held constant at 1, and short idle gaps of one cycle separate frames. These catch strobes that appear without an edge and a rearm that misses a brief drop of frame-active.

// File: rtl/rx_strobe_pkg.sv
package rx_strobe_pkg;

    localparam int unsigned RXS_MIN_DIV = 2;

    typedef enum logic [0:0] {
        SEARCH_EDGE = 1'b0,
        LOCKED      = 1'b1
    } lock_state_e;

endpackage

// File: rtl/rx_edge_sync.sv
module rx_edge_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic din_i,
    output logic level_o,
    output logic fall_o
);
    // pipe[STAGES-1] is the synchronized level; pipe[STAGES] is its previous value
    localparam int unsigned PIPE_W = STAGES + 1;

    typedef struct packed {
        logic [PIPE_W-1:0] pipe;
    } sync_reg_t;

    sync_reg_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        s_d.pipe = {s_q.pipe[PIPE_W-2:0], din_i};
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign level_o = s_q.pipe[STAGES-1];
    assign fall_o  = s_q.pipe[STAGES] & ~s_q.pipe[STAGES-1];

endmodule

// File: rtl/rx_phase_divider.sv
module rx_phase_divider
    import rx_strobe_pkg::*;
#(
    parameter int unsigned DIV_W   = 8,
    parameter int unsigned PHASE_W = 8
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               frame_act_i,
    input  logic               fall_i,
    input  logic [DIV_W-1:0]   div_i,
    input  logic [PHASE_W-1:0] phase_i,
    output logic               tick_pre_o,
    output logic               tick_o
);
    localparam int unsigned CNT_W = ((DIV_W > PHASE_W) ? DIV_W : PHASE_W) + 1;

    typedef struct packed {
        lock_state_e       state;
        logic [CNT_W-1:0]  cnt;
        logic              tick;
    } div_reg_t;

    div_reg_t r_d, r_q;

    logic [CNT_W-1:0] div_eff;
    logic [CNT_W-1:0] phase_ext;
    logic [CNT_W-1:0] first_load;

    always_comb begin
        div_eff    = (div_i < DIV_W'(RXS_MIN_DIV)) ? CNT_W'(RXS_MIN_DIV) : CNT_W'(div_i);
        phase_ext  = CNT_W'(phase_i);
        // countdown reaches 1 after load-1 cycles; strobe is registered one cycle later
        first_load = div_eff + phase_ext - CNT_W'(1);
    end

    always_comb begin
        r_d      = r_q;
        r_d.tick = 1'b0;
        if (!frame_act_i) begin
            r_d.state = SEARCH_EDGE;
            r_d.cnt   = '0;
        end else begin
            unique case (r_q.state)
                SEARCH_EDGE: begin
                    if (fall_i) begin
                        r_d.state = LOCKED;
                        r_d.cnt   = first_load;
                    end
                end
                LOCKED: begin
                    if (r_q.cnt == CNT_W'(1)) begin
                        r_d.tick = 1'b1;
                        r_d.cnt  = div_eff;
                    end else begin
                        r_d.cnt  = r_q.cnt - CNT_W'(1);
                    end
                end
                default: begin
                    r_d.state = SEARCH_EDGE;
                end
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            r_q.state <= SEARCH_EDGE;
            r_q.cnt   <= '0;
            r_q.tick  <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign tick_pre_o = r_d.tick;
    assign tick_o     = r_q.tick;

endmodule

// File: rtl/rx_sample_latch.sv
module rx_sample_latch #(
    parameter int unsigned THR_W = 7
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             tick_pre_i,
    input  logic             level_i,
    input  logic [THR_W-1:0] thr_i,
    output logic             data_o,
    output logic [THR_W-1:0] thr_o
);
    typedef struct packed {
        logic             data;
        logic [THR_W-1:0] thr;
    } smp_reg_t;

    smp_reg_t m_d, m_q;

    always_comb begin
        m_d     = m_q;
        m_d.thr = thr_i;
        if (tick_pre_i) begin
            m_d.data = level_i;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            m_q <= '0;
        end else begin
            m_q <= m_d;
        end
    end

    assign data_o = m_q.data;
    assign thr_o  = m_q.thr;

endmodule

// File: rtl/rx_strobe_gen.sv
module rx_strobe_gen #(
    parameter int unsigned DIV_W       = 8,
    parameter int unsigned PHASE_W     = 8,
    parameter int unsigned THR_W       = 7,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               cmp_bit_i,
    input  logic               frame_act_i,
    input  logic [DIV_W-1:0]   div_ratio_i,
    input  logic [PHASE_W-1:0] phase_ofs_i,
    input  logic [THR_W-1:0]   thr_level_i,
    output logic               strobe_o,
    output logic               data_o,
    output logic [THR_W-1:0]   thr_level_o
);
    logic cmp_level;
    logic cmp_fall;
    logic tick_pre;

    rx_edge_sync #(
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .din_i   (cmp_bit_i),
        .level_o (cmp_level),
        .fall_o  (cmp_fall)
    );

    rx_phase_divider #(
        .DIV_W   (DIV_W),
        .PHASE_W (PHASE_W)
    ) u_div (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .frame_act_i (frame_act_i),
        .fall_i      (cmp_fall),
        .div_i       (div_ratio_i),
        .phase_i     (phase_ofs_i),
        .tick_pre_o  (tick_pre),
        .tick_o      (strobe_o)
    );

    rx_sample_latch #(
        .THR_W (THR_W)
    ) u_smp (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .tick_pre_i (tick_pre),
        .level_i    (cmp_level),
        .thr_i      (thr_level_i),
        .data_o     (data_o),
        .thr_o      (thr_level_o)
    );

endmodule

// File: rtl/rx_strobe_gen_chk.sv
module rx_strobe_gen_chk #(
    parameter int unsigned THR_W = 7
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             frame_act_i,
    input logic [THR_W-1:0] thr_level_i,
    input logic             strobe_o,
    input logic             data_o,
    input logic [THR_W-1:0] thr_level_o
);
    // R6
    strobe_needs_frame_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        strobe_o |-> $past(frame_act_i));

    // R7
    no_back_to_back_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        strobe_o |=> !strobe_o);

    // R8
    data_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !strobe_o |-> $stable(data_o));

    // R9
    thr_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $past(rst_ni) |-> (thr_level_o == $past(thr_level_i)));

    // R1
    always @(posedge clk_i) begin
        if (!rst_ni) begin
            reset_quiet_chk: assert (!strobe_o && !data_o && thr_level_o == '0);
        end
    end

endmodule

bind rx_strobe_gen rx_strobe_gen_chk #(
    .THR_W (THR_W)
) chk_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .frame_act_i (frame_act_i),
    .thr_level_i (thr_level_i),
    .strobe_o    (strobe_o),
    .data_o      (data_o),
    .thr_level_o (thr_level_o)
);

// File: tb/rx_strobe_gen_tb_top.sv
module rx_strobe_gen_tb_top;

    logic       clk_i = 1'b0;
    logic       rst_ni;
    logic       cmp_bit_i;
    logic       frame_act_i;
    logic [7:0] div_ratio_i;
    logic [7:0] phase_ofs_i;
    logic [6:0] thr_level_i;
    logic       strobe_o;
    logic       data_o;
    logic [6:0] thr_level_o;

    always #2 clk_i = ~clk_i;

    rx_strobe_gen dut_i (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .cmp_bit_i   (cmp_bit_i),
        .frame_act_i (frame_act_i),
        .div_ratio_i (div_ratio_i),
        .phase_ofs_i (phase_ofs_i),
        .thr_level_i (thr_level_i),
        .strobe_o    (strobe_o),
        .data_o      (data_o),
        .thr_level_o (thr_level_o)
    );

    int    checks = 0;
    int    fails  = 0;
    bit    done   = 1'b0;
    int    wd_cnt = 0;

    // reference model state
    int    k = 0;
    bit    h1 = 1'b0, h2 = 1'b0, h3 = 1'b0;
    bit    m_armed = 1'b1, m_run = 1'b0, first_pend = 1'b0;
    int    due = 0;
    bit    exp_strobe = 1'b0, exp_data = 1'b0;
    int    exp_thr = 0;
    string exp_tag = "R1";
    bit    meas_pend = 1'b0;
    int    f_cyc = 0, m_d = 2, m_p = 0, m_raw = 2;
    int    last_stb = -1;
    bit    lvl = 1'b1;
    int    run_left = 0;

    task automatic chk(input int act, input int exp, input string req);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d cycle=%0d", req, act, exp, k);
        end
    endtask

    function automatic bit next_level();
        if (run_left == 0) begin
            lvl      = ~lvl;
            run_left = $urandom_range(1, 6);
        end
        run_left--;
        return lvl;
    endfunction

    task automatic step(input bit fa_v, input bit in_v, input logic [6:0] thr_v);
        bit fall;
        bit nstb;
        int deff;
        chk(int'(strobe_o), int'(exp_strobe), exp_tag);
        chk(int'(data_o), int'(exp_data), "R8");
        chk(int'(thr_level_o), exp_thr, "R9");
        if (strobe_o) begin
            if (meas_pend) begin
                chk(k - f_cyc, 2 + m_d + m_p, (m_p == 0) ? "R3" : "R2");
                meas_pend = 1'b0;
            end else if (last_stb >= 0) begin
                chk(k - last_stb, m_d, (m_raw < 2) ? "R7" : "R4");
            end
            last_stb = k;
        end
        frame_act_i = fa_v;
        cmp_bit_i   = in_v;
        thr_level_i = thr_v;
        fall = h3 && !h2;
        deff = (div_ratio_i < 2) ? 2 : int'(div_ratio_i);
        nstb = 1'b0;
        if (!fa_v) begin
            m_armed = 1'b1; m_run = 1'b0; first_pend = 1'b0;
            meas_pend = 1'b0; last_stb = -1;
            exp_tag = "R6";
        end else if (m_armed) begin
            exp_tag = "R10";
            if (fall) begin
                m_armed = 1'b0; m_run = 1'b1; first_pend = 1'b1;
                due = k + deff + int'(phase_ofs_i);
                f_cyc = k - 2; meas_pend = 1'b1;
                m_d = deff; m_p = int'(phase_ofs_i); m_raw = int'(div_ratio_i);
                exp_tag = "R2";
            end
        end else if (m_run) begin
            exp_tag = first_pend ? "R3" : (fall ? "R5" : "R4");
            if (k + 1 == due) begin
                nstb = 1'b1;
                due  = due + deff;
                first_pend = 1'b0;
            end
        end
        exp_strobe = nstb;
        if (nstb) exp_data = h2;
        exp_thr = int'(thr_v);
        h3 = h2; h2 = h1; h1 = in_v;
        k++;
        @(negedge clk_i);
    endtask

    task automatic frame(input int d, input int p, input int len, input int idle, input bit flat);
        div_ratio_i = 8'(d);
        phase_ofs_i = 8'(p);
        for (int i = 0; i < idle; i++) step(1'b0, next_level(), 7'($urandom));
        for (int i = 0; i < len; i++) step(1'b1, flat ? 1'b1 : next_level(), 7'($urandom));
    endtask

    always @(posedge clk_i) begin
        wd_cnt++;
        if (wd_cnt > 150000 && !done) begin
            fails++;
            $display("FAIL watchdog expired actual=%0d expected=0", wd_cnt);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20061012));
        rst_ni      = 1'b0;
        cmp_bit_i   = 1'b1;
        frame_act_i = 1'b1;
        div_ratio_i = 8'd32;
        phase_ofs_i = 8'd0;
        thr_level_i = 7'd99;
        @(negedge clk_i);
        for (int i = 0; i < 3; i++) begin
            chk(int'(strobe_o), 0, "R1");
            chk(int'(data_o), 0, "R1");
            chk(int'(thr_level_o), 0, "R1");
            cmp_bit_i = ~cmp_bit_i;
            @(negedge clk_i);
        end
        cmp_bit_i = 1'b0;
        rst_ni    = 1'b1;
        // directed corners
        frame(32, 0, 300, 4, 1'b0);
        frame(32, 5, 300, 1, 1'b0);
        frame(32, 9, 200, 3, 1'b1);   // R10: no edge
        frame(0, 3, 200, 2, 1'b0);    // R7
        frame(1, 0, 200, 1, 1'b0);    // R7
        frame(2, 0, 200, 1, 1'b0);
        frame(255, 255, 1200, 2, 1'b0);
        frame(7, 1, 150, 1, 1'b1);    // R10
        for (int n = 0; n < 40; n++) begin
            frame($urandom_range(0, 40), $urandom_range(0, 40),
                  $urandom_range(40, 400), $urandom_range(1, 8), ($urandom_range(0, 9) == 0));
        end
        frame(32, 0, 10, 2, 1'b0);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule